// File: doc/BRIEF.md
# Memory Test Traffic Generator

This block drives a burst-oriented memory controller with a deterministic test pattern. After reset it stays idle for a programmable power-up interval. It then enters a fill phase. A free-running 64-step period counter opens a window of eight consecutive cycles in every period. In each cycle of that window one incrementing data word is pushed into an external write FIFO. The linear word address moves forward by one at the end of every period.

A write request is raised whenever the write FIFO holds a full burst of eight words. When the period for the all-ones address has finished, the block switches to readback. It returns the address to zero and stops all write traffic. From then on it requests reads while the read FIFO has room, and it advances the address once each time the controller's read acknowledge falls. A two-bit status output shows whether the block is waiting, filling or reading back.

Top module: `mtg_traffic_gen`

## Requirements
- R1: After reset, for the first DELAY_CYCLES clock edges, status is WAIT (code 0), and no push, no write request and no read request is raised. From edge DELAY_CYCLES onward, status is FILL (code 1).
- R2: In the fill phase, let k be the number of clock edges since status became FILL. The push strobe is high exactly when k mod 64 lies in 6..13, which gives eight pushes per 64-cycle period.
- R3: The write data word is 0 after reset and goes up by one on the clock edge that ends each push cycle. It keeps its value once the fill phase is over.
- R4: In the fill phase the address starts at 0. It goes up by one at the edge that ends period position 63, so it equals floor(k/64).
- R5: The write request is high exactly when status is FILL and the write FIFO level is 8 or more.
- R6: The fill period in which the address is all-ones (2^ADDR_W-1) ends with a single edge. On that edge status becomes READ (code 2) and the address becomes 0. After that, no push and no write request is raised.
- R7: The read request is high exactly when status is READ and the read FIFO level is 256 or less.
- R8: In the read phase, the address goes up by one, modulo 2^ADDR_W, on the first clock edge that samples the read acknowledge low after sampling it high. Acknowledge edges have no effect on the address in the WAIT and FILL phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_level_i | input | LVL_W | Words held in the write FIFO |
| rd_level_i | input | LVL_W | Words held in the read FIFO |
| rd_ack_i | input | 1 | Read burst acknowledge from the controller |
| wr_push_o | output | 1 | Write FIFO push strobe |
| wr_data_o | output | DATA_W | Data word to push |
| wr_req_o | output | 1 | Write burst request |
| rd_req_o | output | 1 | Read burst request |
| addr_o | output | ADDR_W | Linear word address |
| phase_o | output | 2 | Status: 0 wait, 1 fill, 2 read |

## Verification
Some properties are checked by assertions on every cycle:
- Neither request nor the push strobe appears outside its own phase.
- The data word moves only on a push.
- The address holds still between period ends while filling.
- The done flag never clears.
- The address is zero at the switch to readback.
- Each acknowledge fall in readback adds exactly one to the address.

Other behaviour is shown only by the bench's full sweep of a small configuration:
- The exact cycle at which the wait ends.
- The position of the eight-cycle push window in each period.
- The arithmetic value of the data count.
- The cycle of the phase change.
- Address wrap-around during readback.
- The level thresholds at 8 and 256.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
    typedef enum logic [1:0] {
        MTG_WAIT = 2'd0,
        MTG_FILL = 2'd1,
        MTG_READ = 2'd2
    } mtg_phase_e;
endpackage

// File: rtl/mtg_startup.sv
module mtg_startup #(
    parameter int unsigned DELAY_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int unsigned CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ready;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready |=> st_q.ready);
endmodule

// File: rtl/mtg_fill.sv
module mtg_fill #(
    parameter int unsigned PERIOD_W   = 6,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PUSH_FIRST = 6,
    parameter int unsigned PUSH_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              done_i,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o,
    output logic              period_end_o
);
    localparam logic [PERIOD_W-1:0] WIN_LO  = PERIOD_W'(PUSH_FIRST);
    localparam logic [PERIOD_W-1:0] WIN_HI  = PERIOD_W'(PUSH_FIRST + PUSH_COUNT - 1);
    localparam logic [PERIOD_W-1:0] PER_END = '1;

    typedef struct packed {
        logic [PERIOD_W-1:0] tick;
        logic [DATA_W-1:0]   data;
    } st_t;

    st_t  st_d, st_q;
    logic in_window;

    always_comb begin
        in_window = (st_q.tick >= WIN_LO) && (st_q.tick <= WIN_HI);
        push_o    = ready_i && !done_i && in_window;
        st_d      = st_q;
        if (ready_i) st_d.tick = st_q.tick + 1'b1;
        if (push_o)  st_d.data = st_q.data + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o       = st_q.data;
    assign period_end_o = ready_i && (st_q.tick == PER_END);

    assert_data_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> data_o == $past(data_o) + 1'b1);
    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !push_o |=> $stable(data_o));
    assert_no_push_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> !push_o);
endmodule

// File: rtl/mtg_addr.sv
module mtg_addr #(
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end_i,
    input  logic              rd_ack_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              ack;
    } st_t;

    st_t  st_d, st_q;
    logic ack_fall;

    always_comb begin
        ack_fall = st_q.ack && !rd_ack_i;
        st_d     = st_q;
        st_d.ack = rd_ack_i;
        if (!st_q.done) begin
            if (period_end_i) begin
                if (st_q.addr == ADDR_LAST) begin
                    st_d.done = 1'b1;
                    st_d.addr = '0;
                end else begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
        end else if (ack_fall) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign done_o = st_q.done;

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
    assert_addr_zero_at_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> addr_o == '0);
    assert_fill_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !period_end_i) |=> $stable(addr_o));
    assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.ack && !rd_ack_i) |=> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/mtg_traffic_gen.sv
module mtg_traffic_gen #(
    parameter int unsigned DELAY_CYCLES = 100000,
    parameter int unsigned ADDR_W       = 22,
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned LVL_W        = 9,
    parameter int unsigned BURST_LEN    = 8,
    parameter int unsigned RD_ROOM      = 256,
    parameter int unsigned PERIOD_W     = 6,
    parameter int unsigned PUSH_FIRST   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  wr_level_i,
    input  logic [LVL_W-1:0]  rd_level_i,
    input  logic              rd_ack_i,
    output logic              wr_push_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              wr_req_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        phase_o
);
    import mtg_pkg::*;

    localparam logic [LVL_W-1:0] BURST_LVL = LVL_W'(BURST_LEN);
    localparam logic [LVL_W-1:0] ROOM_LVL  = LVL_W'(RD_ROOM);

    logic       ready, done, period_end;
    mtg_phase_e phase;

    mtg_startup #(.DELAY_CYCLES(DELAY_CYCLES)) startup_i (
        .clk(clk), .rst_n(rst_n), .ready_o(ready)
    );

    mtg_fill #(
        .PERIOD_W(PERIOD_W), .DATA_W(DATA_W),
        .PUSH_FIRST(PUSH_FIRST), .PUSH_COUNT(BURST_LEN)
    ) fill_i (
        .clk(clk), .rst_n(rst_n), .ready_i(ready), .done_i(done),
        .push_o(wr_push_o), .data_o(wr_data_o), .period_end_o(period_end)
    );

    mtg_addr #(.ADDR_W(ADDR_W)) addr_i (
        .clk(clk), .rst_n(rst_n), .period_end_i(period_end),
        .rd_ack_i(rd_ack_i), .addr_o(addr_o), .done_o(done)
    );

    always_comb begin
        if (done)       phase = MTG_READ;
        else if (ready) phase = MTG_FILL;
        else            phase = MTG_WAIT;
        wr_req_o = (phase == MTG_FILL) && (wr_level_i >= BURST_LVL);
        rd_req_o = (phase == MTG_READ) && (rd_level_i <= ROOM_LVL);
    end

    assign phase_o = phase;

    assert_wr_req_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> phase_o == MTG_FILL);
    assert_rd_req_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> phase_o == MTG_READ);
    assert_push_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push_o |-> phase_o == MTG_FILL);
endmodule

// File: tb/mtg_traffic_gen_tb_top.sv
`timescale 1ns/1ps
module mtg_traffic_gen_tb_top;
    localparam int D  = 20;
    localparam int AW = 4;
    localparam int N  = (1 << AW) * 64;
    localparam int READ_CYC = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  wr_level = '0;
    logic [8:0]  rd_level = '0;
    logic        rd_ack = 1'b0;
    logic        wr_push, wr_req, rd_req;
    logic [15:0] wr_data;
    logic [AW-1:0] addr;
    logic [1:0]  phase;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mtg_traffic_gen #(.DELAY_CYCLES(D), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_level_i(wr_level), .rd_level_i(rd_level),
        .rd_ack_i(rd_ack), .wr_push_o(wr_push), .wr_data_o(wr_data),
        .wr_req_o(wr_req), .rd_req_o(rd_req), .addr_o(addr), .phase_o(phase)
    );

    task automatic chk(input string req, input int act, input int exp, input int cyc);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic int rd_lvl_pick(input int k);
        case (k % 8)
            0: return 0;   1: return 255; 2: return 256; 3: return 257;
            4: return 300; 5: return 511; 6: return 128; default: return 256;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int rd_addr = 0;
        bit ack_reg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset phase", phase, 0, 0);
        chk("R1 reset push", wr_push, 0, 0);
        chk("R1 reset addr", addr, 0, 0);
        chk("R3 reset data", wr_data, 0, 0);
        rst_n = 1'b1;
        for (int i = 1; i <= D + N + READ_CYC; i++) begin
            int j, ph, exp_push, exp_data, exp_addr, exp_phase;
            bit a;
            @(negedge clk);
            j = i - D;
            if (i < D) begin
                exp_phase = 0; exp_push = 0; exp_data = 0; exp_addr = 0;
            end else if (j < N) begin
                ph = j % 64;
                exp_phase = 1;
                exp_push  = (ph >= 6 && ph <= 13) ? 1 : 0;
                exp_data  = 8 * (j / 64) + ((ph < 6) ? 0 : ((ph > 14) ? 8 : ph - 6));
                exp_addr  = j / 64;
            end else begin
                exp_phase = 2; exp_push = 0; exp_data = 8 * (1 << AW);
                exp_addr  = rd_addr % (1 << AW);
            end
            chk("R1/R6 phase", phase, exp_phase, i);
            chk("R2 push window", wr_push, exp_push, i);
            chk("R3 data count", wr_data, exp_data, i);
            chk("R4/R6/R8 address", addr, exp_addr, i);
            // R5 and R7: request thresholds against the levels driven now
            chk("R5 wr_req", wr_req, (exp_phase == 1 && wr_level >= 8) ? 1 : 0, i);
            chk("R7 rd_req", rd_req, (exp_phase == 2 && rd_level <= 256) ? 1 : 0, i);
            // drive next inputs
            wr_level = (i % 4 == 0) ? 9'(i % 16) : 9'((i * 37) % 512);
            rd_level = 9'(rd_lvl_pick(i));
            if (i < D)      a = (i % 3 == 0);
            else if (j < N) a = ((j % 64) < 32) && ((j % 5) < 2); // R8: ignored while filling
            else            a = (((j - N) / 3) % 2 == 1);
            rd_ack = a;
            if (i >= D && j >= N && ack_reg && !a) rd_addr++;
            ack_reg = a;
        end
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule